// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Relocatable Vectors

This block gathers interrupt requests from a reset request, a non-maskable request, four external lines, a serial receiver, a serial transmitter, a timer and a software trap channel. It picks one winner by fixed priority and offers that winner's vector address to the CPU on a valid/ready channel. The address is a programmable page base at a 2048-word boundary plus twice the winner's slot number. When the CPU accepts the offer, the block acknowledges the serviced source with a one-cycle pulse on `irq_ack`.

The seven maskable sources each have a flag bit and an enable bit. Software writes these through a plain register port and reads them back on status outputs. A global enable drops when any interrupt is taken and comes back when the CPU signals a return. While the CPU reports a multicycle, repeated or wait-stated instruction on `cpu_busy`, no new offer is formed. The only exception is the reset request.

Back-pressure on the offer channel: once `irq_valid` is high, the vector and the source stay fixed until the cycle in which `irq_ready` is high. That includes the case where a higher priority request arrives in the meantime. The software trap input is a valid/ready channel with a depth of one. `sw_ready` is low from the cycle after a trap is accepted until that trap is acknowledged.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After `rst_n` is released, the outputs read as follows: `irq_valid`=0, `irq_ack`=0, `flag_o`=0, `mask_o`=0, `page_o`=0, `gie_o`=1 and `sw_ready`=1.
- R2: A flag bit sets on a rising edge of its request line. The flag bit order is: bit0-3 external lines 1-4, bit4 serial receive, bit5 serial transmit, bit6 timer. The flag is visible one cycle after the edge is sampled. The offer is visible one cycle after that.
- R3: A maskable source is offered only while its `mask_o` bit is 1. A masked source keeps its flag set and is offered once it is enabled.
- R4: A register write with `reg_op`=1 sets each flag whose `reg_wdata` bit is 1. `reg_op`=2 clears each such flag. `reg_op`=0 loads the enable mask.
- R5: The priority order and slot numbers are: reset 0, non-maskable 1, external 1-4 at 2-5, serial receive 6, serial transmit 7, timer 8, then the software trap. A lower slot number wins.
- R6: Reset and non-maskable requests are latched on a rising edge, have no mask, and ignore the global enable. The reset request also ignores `cpu_busy`.
- R7: `irq_vector` = `page_o`*2048 + 2*slot. A write with `reg_op`=3 loads the page field from the low bits of `reg_wdata`.
- R8: No offer other than reset is formed while `cpu_busy` is high. A held request is offered one cycle after `cpu_busy` falls.
- R9: When `irq_valid` and `irq_ready` are both high, `irq_ack` pulses one bit in that cycle. The bit order is: bit0 reset, bit1 non-maskable, bits 2-8 the maskable sources in flag order, bit9 software trap. The pulse clears that source's pending state and clears `gie_o`. While ready is low, the offer holds steady.
- R10: A one-cycle `cpu_return` pulse sets `gie_o` again, and pending maskable sources can then be offered.
- R11: A software trap is accepted when `sw_valid` and `sw_ready` are both high. It is offered with slot number `sw_index`, regardless of the mask and the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rs_req | input | 1 | Reset request (rising edge) |
| nmi_req | input | 1 | Non-maskable request (rising edge) |
| ext_req | input | 4 | External request lines 1-4 |
| srx_req | input | 1 | Serial receive request |
| stx_req | input | 1 | Serial transmit request |
| tmr_req | input | 1 | Timer request |
| sw_valid | input | 1 | Software trap valid |
| sw_index | input | 5 | Software trap slot number |
| sw_ready | output | 1 | Software trap channel free |
| cpu_busy | input | 1 | CPU inside a multicycle instruction |
| cpu_return | input | 1 | Return from interrupt pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_op | input | 2 | 0 mask load, 1 flag set, 2 flag clear, 3 page load |
| reg_wdata | input | 7 | Register write data |
| mask_o | output | 7 | Enable mask readback |
| flag_o | output | 7 | Flag readback |
| page_o | output | 5 | Vector page readback |
| gie_o | output | 1 | Global enable |
| irq_valid | output | 1 | Vector offer valid |
| irq_ready | input | 1 | CPU accepts offer |
| irq_vector | output | 16 | Vector address |
| irq_ack | output | 10 | One-hot acknowledge |

## Verification
Each request edge that is driven before a clock edge becomes a flag at that edge and an offer at the next. The bench checks both stages: the flag one sample after the drive, and `irq_valid` one sample later. Its inputs change on the falling edge and its outputs are sampled on the falling edge. A register write, a `cpu_return` pulse or a drop of `cpu_busy` each lead to an offer exactly one clock edge later, and the bench checks at that sample. `irq_ack` is combinational on the handshake, so it is checked a moment after `irq_ready` is raised, within the same cycle. The cleared flag and the cleared `gie_o` are checked after the next edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    OP_MASK = 2'd0,
    OP_FSET = 2'd1,
    OP_FCLR = 2'd2,
    OP_PAGE = 2'd3
  } reg_op_e;

  localparam int SLOT_RST  = 0;
  localparam int SLOT_NMI  = 1;
  localparam int SLOT_MSK0 = 2;
endpackage

// File: rtl/irqc_flags.sv
module irqc_flags
  import irqc_pkg::*;
#(
  parameter int NM = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NM-1:0] req,
  input  logic          reg_wr,
  input  reg_op_e       reg_op,
  input  logic [NM-1:0] wdata,
  input  logic [NM-1:0] ack_m,
  output logic [NM-1:0] flag,
  output logic [NM-1:0] en
);
  logic [NM-1:0] prev;
  logic          wr_set, wr_clr;

  assign wr_set = reg_wr && (reg_op == OP_FSET);
  assign wr_clr = reg_wr && (reg_op == OP_FCLR);

  for (genvar i = 0; i < NM; i++) begin : g_bit
    logic set_i, clr_i;
    assign set_i = (req[i] && !prev[i]) || (wr_set && wdata[i]);
    assign clr_i = ack_m[i] || (wr_clr && wdata[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev[i] <= 1'b0;
        flag[i] <= 1'b0;
      end else begin
        prev[i] <= req[i];
        if (set_i)      flag[i] <= 1'b1;
        else if (clr_i) flag[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              en <= '0;
    else if (reg_wr && (reg_op == OP_MASK))  en <= wdata;
  end
endmodule

// File: rtl/irqc_special.sv
module irqc_special #(
  parameter int SWI_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rs_req,
  input  logic             nmi_req,
  input  logic             sw_valid,
  input  logic [SWI_W-1:0] sw_index,
  output logic             sw_ready,
  input  logic             cpu_return,
  input  logic             take,
  input  logic             ack_rs,
  input  logic             ack_nmi,
  input  logic             ack_sw,
  output logic             rs_pend,
  output logic             nmi_pend,
  output logic             sw_pend,
  output logic [SWI_W-1:0] sw_idx,
  output logic             gie
);
  logic rs_prev, nmi_prev;

  assign sw_ready = !sw_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_prev  <= 1'b0;
      nmi_prev <= 1'b0;
      rs_pend  <= 1'b0;
      nmi_pend <= 1'b0;
      sw_pend  <= 1'b0;
      sw_idx   <= '0;
      gie      <= 1'b1;
    end else begin
      rs_prev  <= rs_req;
      nmi_prev <= nmi_req;
      if (rs_req && !rs_prev)       rs_pend <= 1'b1;
      else if (ack_rs)              rs_pend <= 1'b0;
      if (nmi_req && !nmi_prev)     nmi_pend <= 1'b1;
      else if (ack_nmi)             nmi_pend <= 1'b0;
      if (sw_valid && sw_ready) begin
        sw_pend <= 1'b1;
        sw_idx  <= sw_index;
      end else if (ack_sw) begin
        sw_pend <= 1'b0;
      end
      if (take)            gie <= 1'b0;
      else if (cpu_return) gie <= 1'b1;
    end
  end

  a_r11_sw_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_valid && sw_ready) |=> !sw_ready);
  a_r9_gie_clear: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !gie);
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int NM    = 7,
  parameter int SWI_W = 5,
  localparam int NS    = NM + 3,
  localparam int SRC_W = $clog2(NS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rs_pend,
  input  logic             nmi_pend,
  input  logic [NM-1:0]    msk_pend,
  input  logic             sw_pend,
  input  logic [SWI_W-1:0] sw_idx,
  input  logic             gie,
  input  logic             busy,
  input  logic             irq_ready,
  output logic             irq_valid,
  output logic [SWI_W-1:0] slot,
  output logic [NS-1:0]    ack
);
  logic [NS-1:0]    cand;
  logic [SRC_W-1:0] win;
  logic             win_any;
  logic [SRC_W-1:0] st_src;
  logic             take;

  always_comb begin
    cand          = '0;
    cand[0]       = rs_pend;
    cand[1]       = nmi_pend && !busy;
    for (int i = 0; i < NM; i++) cand[2+i] = msk_pend[i] && gie && !busy;
    cand[NS-1]    = sw_pend && !busy;
  end

  always_comb begin
    win     = '0;
    win_any = 1'b0;
    for (int i = NS-1; i >= 0; i--) begin
      if (cand[i]) begin
        win     = SRC_W'(i);
        win_any = 1'b1;
      end
    end
  end

  assign take = irq_valid && irq_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      st_src    <= '0;
      slot      <= '0;
    end else if (!irq_valid) begin
      if (win_any) begin
        irq_valid <= 1'b1;
        st_src    <= win;
        slot      <= (win == SRC_W'(NS-1)) ? sw_idx : SWI_W'(win);
      end
    end else if (irq_ready) begin
      irq_valid <= 1'b0;
    end
  end

  always_comb begin
    ack = '0;
    if (take) ack[st_src] = 1'b1;
  end

  a_r9_offer_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready) |=> (irq_valid && $stable(slot)));
  a_r9_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack));
  a_r8_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_valid) && st_src != '0) |-> !$past(busy));
endmodule

// File: rtl/irqc_vector.sv
module irqc_vector
  import irqc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PAGE_SHIFT = 11,
  parameter int SWI_W      = 5,
  localparam int PG_W      = ADDR_W - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  reg_op_e           reg_op,
  input  logic [PG_W-1:0]   wdata,
  input  logic [SWI_W-1:0]  slot,
  output logic [PG_W-1:0]   page,
  output logic [ADDR_W-1:0] vector
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             page <= '0;
    else if (reg_wr && (reg_op == OP_PAGE)) page <= wdata;
  end

  assign vector = {page, {PAGE_SHIFT{1'b0}}} | ADDR_W'({slot, 1'b0});
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int N_EXT      = 4,
  parameter int SWI_W      = 5,
  parameter int ADDR_W     = 16,
  parameter int PAGE_SHIFT = 11,
  localparam int NM   = N_EXT + 3,
  localparam int NS   = NM + 3,
  localparam int PG_W = ADDR_W - PAGE_SHIFT,
  localparam int RW   = (NM > PG_W) ? NM : PG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rs_req,
  input  logic              nmi_req,
  input  logic [N_EXT-1:0]  ext_req,
  input  logic              srx_req,
  input  logic              stx_req,
  input  logic              tmr_req,
  input  logic              sw_valid,
  input  logic [SWI_W-1:0]  sw_index,
  output logic              sw_ready,
  input  logic              cpu_busy,
  input  logic              cpu_return,
  input  logic              reg_wr,
  input  logic [1:0]        reg_op,
  input  logic [RW-1:0]     reg_wdata,
  output logic [NM-1:0]     mask_o,
  output logic [NM-1:0]     flag_o,
  output logic [PG_W-1:0]   page_o,
  output logic              gie_o,
  output logic              irq_valid,
  input  logic              irq_ready,
  output logic [ADDR_W-1:0] irq_vector,
  output logic [NS-1:0]     irq_ack
);
  reg_op_e          op;
  logic [NM-1:0]    req_m;
  logic             rs_pend, nmi_pend, sw_pend;
  logic [SWI_W-1:0] sw_idx, slot;

  assign op    = reg_op_e'(reg_op);
  assign req_m = {tmr_req, stx_req, srx_req, ext_req};

  irqc_flags #(.NM(NM)) u_flags (
    .clk(clk), .rst_n(rst_n), .req(req_m), .reg_wr(reg_wr), .reg_op(op),
    .wdata(reg_wdata[NM-1:0]), .ack_m(irq_ack[SLOT_MSK0 +: NM]),
    .flag(flag_o), .en(mask_o)
  );

  irqc_special #(.SWI_W(SWI_W)) u_special (
    .clk(clk), .rst_n(rst_n), .rs_req(rs_req), .nmi_req(nmi_req),
    .sw_valid(sw_valid), .sw_index(sw_index), .sw_ready(sw_ready),
    .cpu_return(cpu_return), .take(|irq_ack),
    .ack_rs(irq_ack[SLOT_RST]), .ack_nmi(irq_ack[SLOT_NMI]), .ack_sw(irq_ack[NS-1]),
    .rs_pend(rs_pend), .nmi_pend(nmi_pend), .sw_pend(sw_pend),
    .sw_idx(sw_idx), .gie(gie_o)
  );

  irqc_arbiter #(.NM(NM), .SWI_W(SWI_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .rs_pend(rs_pend), .nmi_pend(nmi_pend),
    .msk_pend(flag_o & mask_o), .sw_pend(sw_pend), .sw_idx(sw_idx),
    .gie(gie_o), .busy(cpu_busy), .irq_ready(irq_ready),
    .irq_valid(irq_valid), .slot(slot), .ack(irq_ack)
  );

  irqc_vector #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .SWI_W(SWI_W)) u_vec (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_op(op),
    .wdata(reg_wdata[PG_W-1:0]), .slot(slot), .page(page_o), .vector(irq_vector)
  );

  a_r7_align: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !irq_vector[0]);
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rs_req = 0, nmi_req = 0, srx_req = 0, stx_req = 0, tmr_req = 0;
  logic [3:0]  ext_req = '0;
  logic        sw_valid = 0;
  logic [4:0]  sw_index = '0;
  logic        sw_ready;
  logic        cpu_busy = 0, cpu_return = 0;
  logic        reg_wr = 0;
  logic [1:0]  reg_op = '0;
  logic [6:0]  reg_wdata = '0;
  logic [6:0]  mask_o, flag_o;
  logic [4:0]  page_o;
  logic        gie_o, irq_valid;
  logic        irq_ready = 0;
  logic [15:0] irq_vector;
  logic [9:0]  irq_ack;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .rs_req(rs_req), .nmi_req(nmi_req),
    .ext_req(ext_req), .srx_req(srx_req), .stx_req(stx_req), .tmr_req(tmr_req),
    .sw_valid(sw_valid), .sw_index(sw_index), .sw_ready(sw_ready),
    .cpu_busy(cpu_busy), .cpu_return(cpu_return), .reg_wr(reg_wr),
    .reg_op(reg_op), .reg_wdata(reg_wdata), .mask_o(mask_o), .flag_o(flag_o),
    .page_o(page_o), .gie_o(gie_o), .irq_valid(irq_valid), .irq_ready(irq_ready),
    .irq_vector(irq_vector), .irq_ack(irq_ack)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic regw(logic [1:0] op, logic [6:0] d);
    reg_wr = 1; reg_op = op; reg_wdata = d;
    tick(1);
    reg_wr = 0;
  endtask

  task automatic take(string r, logic [15:0] vec, logic [9:0] ackv);
    chk({r, " valid"}, irq_valid, 1);
    chk({r, " vector"}, irq_vector, vec);
    irq_ready = 1;
    #1;
    chk({r, " ack"}, irq_ack, ackv);
    tick(1);
    irq_ready = 0;
  endtask

  task automatic ret();
    cpu_return = 1;
    tick(1);
    cpu_return = 0;
  endtask

  task automatic t_reset();
    chk("R1 valid", irq_valid, 0);
    chk("R1 ack", irq_ack, 0);
    chk("R1 flag", flag_o, 0);
    chk("R1 mask", mask_o, 0);
    chk("R1 page", page_o, 0);
    chk("R1 gie", gie_o, 1);
    chk("R1 sw_ready", sw_ready, 1);
  endtask

  task automatic t_latency();
    regw(2'd0, 7'h01);
    ext_req[0] = 1; tick(1); ext_req[0] = 0;
    chk("R2 flag set", flag_o, 7'h01);
    chk("R2 no early offer", irq_valid, 0);
    tick(1);
    take("R2 ext1", 16'd4, 10'h004);
    chk("R9 flag cleared", flag_o, 0);
    chk("R9 gie cleared", gie_o, 0);
    ret();
    chk("R10 gie set", gie_o, 1);
  endtask

  task automatic t_priority();
    regw(2'd0, 7'h7F);
    ext_req = 4'b1001; tmr_req = 1; tick(1); ext_req = 0; tmr_req = 0;
    tick(1);
    take("R5 ext1 first", 16'd4, 10'h004);
    tick(2);
    chk("R9 no offer while gie low", irq_valid, 0);
    ret(); tick(1);
    take("R5 ext4 second", 16'd10, 10'h020);
    ret(); tick(1);
    take("R5 timer last", 16'd16, 10'h100);
    ret();
  endtask

  task automatic t_masked();
    regw(2'd0, 7'h3F);
    tmr_req = 1; tick(1); tmr_req = 0;
    tick(4);
    chk("R3 masked not offered", irq_valid, 0);
    chk("R3 flag kept", flag_o, 7'h40);
    regw(2'd0, 7'h7F);
    tick(1);
    take("R3 offered after enable", 16'd16, 10'h100);
    ret();
  endtask

  task automatic t_soft();
    regw(2'd0, 7'h00);
    regw(2'd1, 7'h12);
    chk("R4 set flags", flag_o, 7'h12);
    tick(2);
    chk("R3 set flags masked", irq_valid, 0);
    regw(2'd2, 7'h02);
    chk("R4 clear flag", flag_o, 7'h10);
    regw(2'd0, 7'h10);
    tick(1);
    take("R4 rx from soft flag", 16'd12, 10'h040);
    chk("R4 flag empty", flag_o, 0);
    ret();
  endtask

  task automatic t_nmi();
    regw(2'd0, 7'h7F);
    nmi_req = 1; ext_req[0] = 1; tick(1); nmi_req = 0; ext_req[0] = 0;
    tick(1);
    take("R5 nmi beats ext1", 16'd2, 10'h002);
    nmi_req = 1; tick(1); nmi_req = 0;
    tick(1);
    take("R6 nmi ignores gie", 16'd2, 10'h002);
    chk("R6 ext1 waits for gie", irq_valid, 0);
    ret(); tick(1);
    take("R10 ext1 after return", 16'd4, 10'h004);
    ret();
  endtask

  task automatic t_page();
    regw(2'd3, 7'h03);
    chk("R7 page read", page_o, 3);
    ext_req[1] = 1; tick(1); ext_req[1] = 0;
    tick(1);
    take("R7 relocated vector", 16'h1806, 10'h008);
    ret();
    regw(2'd3, 7'h00);
  endtask

  task automatic t_holdoff();
    cpu_busy = 1;
    srx_req = 1; tick(1); srx_req = 0;
    tick(4);
    chk("R8 held while busy", irq_valid, 0);
    cpu_busy = 0;
    tick(1);
    take("R8 offered after busy", 16'd12, 10'h040);
    ret();
  endtask

  task automatic t_rsreq();
    cpu_busy = 1;
    rs_req = 1; tick(1); rs_req = 0;
    tick(1);
    take("R6 reset ignores busy", 16'd0, 10'h001);
    cpu_busy = 0;
    ret();
  endtask

  task automatic t_hold_offer();
    tmr_req = 1; tick(1); tmr_req = 0;
    tick(1);
    chk("R9 timer offered", irq_vector, 16'd16);
    nmi_req = 1; tick(1); nmi_req = 0;
    tick(2);
    chk("R9 offer held valid", irq_valid, 1);
    chk("R9 offer held vector", irq_vector, 16'd16);
    take("R9 timer taken", 16'd16, 10'h100);
    tick(1);
    take("R6 nmi next", 16'd2, 10'h002);
    ret();
  endtask

  task automatic t_sw();
    regw(2'd0, 7'h00);
    chk("R11 ready idle", sw_ready, 1);
    sw_valid = 1; sw_index = 5'd20;
    tick(1);
    sw_valid = 0;
    chk("R11 ready busy", sw_ready, 0);
    tick(1);
    take("R11 trap vector", 16'd40, 10'h200);
    chk("R11 ready again", sw_ready, 1);
    sw_valid = 1; sw_index = 5'd3;
    tick(1);
    sw_valid = 0;
    tick(1);
    take("R11 trap ignores gie", 16'd6, 10'h200);
    ret();
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    t_reset();
    t_latency();
    t_priority();
    t_masked();
    t_soft();
    t_nmi();
    t_page();
    t_holdoff();
    t_rsreq();
    t_hold_offer();
    t_sw();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule